// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs single clause-22 management transactions toward an Ethernet PHY. The host sees two 16-bit registers. The first is a command word that holds a PHY address, a register number, a write flag and a read-only idle flag. The second is a data word. Writing the command word starts one serial frame on the management clock and data pins. When the frame ends, the idle flag rises again.

For a write, the host loads the data word and then writes the command word. For a read, the host writes the command word, polls until the idle flag returns to 1, and then reads the data word, which now holds the 16 bits captured from the PHY. The management clock comes from the system clock through a parameterised divider. It stays low between transactions. During a read, the data pin is released from the turnaround onward. An absent PHY therefore returns all ones through the board pull-up.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the idle flag (command bit 14) reads 1, the data word reads 0, `mdc` is low and `mdio_oe` is low.
- R2: Command word fields are: register number in bits 4:0, PHY address in bits 12:8, write flag in bit 13 (1 = write, 0 = read), idle flag in bit 14. On readback, bits 7:5 and 15 are 0 and written values there are ignored. The idle flag cannot be written.
- R3: A write frame is 64 bits, each sent MSB first, all driven by the block: 32 ones, start `01`, opcode `01`, 5-bit PHY address, 5-bit register number, turnaround `10`, then the 16-bit data word.
- R4: A read frame drives 32 ones, start `01`, opcode `10`, the address and the register number. `mdio_oe` is low for the last 18 bits, from the turnaround onward. The 16 bits sampled during the data phase are in the data word once the idle flag is 1 again.
- R5: `mdc` is low while idle. During a frame it has a period of 2*CLK_DIV system clocks, and it rises CLK_DIV clocks after the command write. `mdio_o` changes only on `mdc` falling edges, and the PHY's bit is sampled on rising edges.
- R6: The idle flag reads 0 in the cycle after a command write. It returns to 1 exactly 128*CLK_DIV system clocks after that write, at the 64th `mdc` falling edge.
- R7: A command write while a frame is in progress is ignored: the readback and the frame in flight are unchanged.
- R8: A read addressed to a PHY that never drives the line returns 0xFFFF.
- R9: A data word write while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 1 | Register select for read and write: 0 command, 1 data |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (resolved line) |

## Verification
The hardest situation to create is a host access that lands in the middle of a frame, because the block must ignore it and leave the bits on the wire untouched. The bench therefore writes a conflicting command word and a new data word partway through a write frame. It then compares the whole 64-bit line sequence recorded at each `mdc` rising edge with the frame predicted from the first command. A bench responder also drives the turnaround and data bits only for its own address. This exercises both the captured read path and the pull-up path seen by an absent PHY.

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_sel,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DIV_W     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             busy;
  logic             mdc_q;
  logic [DIV_W-1:0] div_cnt;
  logic [5:0]       bit_cnt;
  logic [63:0]      frame_q;
  logic [4:0]       ctl_reg, ctl_phy;
  logic             ctl_wr;
  logic [15:0]      data_q;

  wire tick    = busy && (div_cnt == DIV_LAST);
  wire rise_ev = tick && !mdc_q;
  wire fall_ev = tick && mdc_q;
  wire cmd_go  = host_we && !host_sel && !busy;
  wire dat_wr  = host_we && host_sel && !busy;
  wire cmd_wr  = host_wdata[13];

  assign mdc        = mdc_q;
  assign mdio_o     = frame_q[~bit_cnt];
  assign mdio_oe    = busy && (ctl_wr || bit_cnt < 6'(TA_POS));
  assign host_rdata = host_sel ? data_q
                               : {1'b0, ~busy, ctl_wr, ctl_phy, 3'b000, ctl_reg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mdc_q   <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      frame_q <= '0;
      ctl_reg <= '0;
      ctl_phy <= '0;
      ctl_wr  <= 1'b0;
      data_q  <= '0;
    end else begin
      if (cmd_go) begin
        busy    <= 1'b1;
        div_cnt <= '0;
        bit_cnt <= '0;
        mdc_q   <= 1'b0;
        ctl_reg <= host_wdata[4:0];
        ctl_phy <= host_wdata[12:8];
        ctl_wr  <= cmd_wr;
        frame_q <= {32'hFFFF_FFFF, 2'b01, cmd_wr ? 2'b01 : 2'b10,
                    host_wdata[12:8], host_wdata[4:0],
                    cmd_wr ? 2'b10 : 2'b11, cmd_wr ? data_q : 16'hFFFF};
      end else if (busy) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) mdc_q <= ~mdc_q;
        if (fall_ev) begin
          if (bit_cnt == 6'd63) busy <= 1'b0;
          else                  bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (dat_wr) data_q <= host_wdata;
      else if (rise_ev && !ctl_wr && bit_cnt >= 6'(DATA_POS))
        data_q <= {data_q[14:0], mdio_i};
    end
  end

  // R5
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R5
  mdio_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall_ev)) |-> $stable(mdio_o));

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_we && !host_sel) |=> busy);

  // R6
  end_on_last_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(mdc_q) && $past(bit_cnt) == 6'd63));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && !host_sel) |=> $stable({ctl_wr, ctl_phy, ctl_reg, frame_q}));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr && host_we && host_sel) |=> $stable(data_q));

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_cmd_engine.sv
module tb_mdio_cmd_engine;
  localparam int DIV = 4;
  localparam logic [4:0] PHY_ADDR = 5'd9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, host_we = 1'b0, host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic phy_en = 1'b0, phy_bit = 1'b1;
  wire  mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_cmd_engine #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line));

  int checks = 0, fails = 0, rise_total = 0, base_rise = 0;
  logic [63:0] line_rec = '0, oe_rec = '0;
  realtime last_rise = 0, rise_gap = 0;
  logic phy_act = 1'b0;
  logic [15:0] phy_val = '0;

  function automatic logic [15:0] phy_reg_val(input logic [4:0] r);
    return 16'h1357 + 16'({r, 3'b101} * 16'h0823);
  endfunction

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] a,
      input logic [4:0] r, input logic [15:0] d, input logic present);
    if (wr) return {32'hFFFF_FFFF, 2'b01, 2'b01, a, r, 2'b10, d};
    if (present) return {32'hFFFF_FFFF, 2'b01, 2'b10, a, r, 2'b10, phy_reg_val(r)};
    return {32'hFFFF_FFFF, 2'b01, 2'b10, a, r, 2'b11, 16'hFFFF};
  endfunction

  always @(posedge mdc) begin
    int k;
    k = rise_total - base_rise;
    if (k >= 0 && k < 64) begin
      line_rec[63-k] <= mdio_line;
      oe_rec[63-k]   <= mdio_oe;
    end
    rise_gap   = $realtime - last_rise;
    last_rise  = $realtime;
    rise_total = rise_total + 1;
  end

  always @(negedge mdc) begin
    int k;
    k = rise_total - base_rise;
    if (k == 46) begin
      phy_act = (line_rec[29:28] == 2'b10) && (line_rec[27:23] == PHY_ADDR);
      phy_val = phy_reg_val(line_rec[22:18]);
      phy_en  = 1'b0;
    end else if (phy_act && k == 47) begin
      phy_en = 1'b1; phy_bit = 1'b0;
    end else if (phy_act && k >= 48 && k <= 63) begin
      phy_bit = phy_val[63-k];
    end else if (k >= 64) begin
      phy_en = 1'b0; phy_act = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic run_cmd(input logic wr, input logic [4:0] a, input logic [4:0] r,
                         input logic [15:0] d, input logic [2:0] junk,
                         input logic poke);
    logic [15:0] cw, exp_cw;
    realtime t0;
    int cyc;
    logic present;
    present = !wr && (a == PHY_ADDR);
    if (wr) host_write(1'b1, d);
    base_rise = rise_total;
    cw = {junk[2], junk[1], wr, a, junk, r};
    exp_cw = {1'b0, 1'b1, wr, a, 3'b000, r};
    host_write(1'b0, cw);
    t0 = $realtime;
    host_sel = 1'b0; #0;
    chk(host_rdata[14] == 1'b0, "R6 idle drops", 64'(host_rdata[14]), 64'd0);
    if (poke) begin
      repeat (100) @(negedge clk);
      host_write(1'b0, {~wr, ~a, 3'b0, ~r} | 16'h4000);
      host_write(1'b1, ~d);
      host_sel = 1'b0; #0;
      chk(host_rdata == (exp_cw & 16'hBFFF), "R7 busy cmd write ignored",
          64'(host_rdata), 64'(exp_cw & 16'hBFFF));
    end
    host_sel = 1'b0;
    #1;
    while (!host_rdata[14]) @(negedge clk);
    cyc = int'(($realtime - t0) / 8.0);
    if (!poke) chk(cyc == 128*DIV, "R6 frame length", 64'(cyc), 64'(128*DIV));
    chk(line_rec == exp_frame(wr, a, r, d, present), wr ? "R3 write frame" :
        (present ? "R4 read frame" : "R8 absent frame"), line_rec,
        exp_frame(wr, a, r, d, present));
    chk(oe_rec == (wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000),
        wr ? "R3 drive enable" : "R4 release", oe_rec,
        wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000);
    chk(host_rdata == exp_cw, "R2 command readback", 64'(host_rdata), 64'(exp_cw));
    chk(mdc == 1'b0 && rise_gap == realtime'(2*DIV*8), "R5 mdc idle and period",
        {32'(mdc), 32'(int'(rise_gap))}, {32'd0, 32'(2*DIV*8)});
    host_sel = 1'b1; #1;
    if (wr) chk(host_rdata == d, poke ? "R9 busy data write ignored" : "R3 data kept",
                64'(host_rdata), 64'(d));
    else chk(host_rdata == (present ? phy_reg_val(r) : 16'hFFFF),
             present ? "R4 read data" : "R8 absent reads ones", 64'(host_rdata),
             64'(present ? phy_reg_val(r) : 16'hFFFF));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    host_sel = 1'b0; #1;
    chk(host_rdata == 16'h4000 && !mdc && !mdio_oe, "R1 reset command state",
        {32'(host_rdata), 29'd0, mdc, mdio_oe, 1'b0}, 64'h0000_4000_0000_0000);
    host_sel = 1'b1; #1;
    chk(host_rdata == 16'h0000, "R1 reset data", 64'(host_rdata), 64'd0);
    run_cmd(1'b1, PHY_ADDR, 5'd4, 16'hBEEF, 3'b000, 1'b0);
    run_cmd(1'b0, PHY_ADDR, 5'd2, 16'h0, 3'b111, 1'b0);
    run_cmd(1'b0, 5'd31, 5'd1, 16'h0, 3'b010, 1'b0);
    run_cmd(1'b0, PHY_ADDR, 5'd31, 16'h0, 3'b000, 1'b0);
    run_cmd(1'b1, 5'd0, 5'd0, 16'h0001, 3'b101, 1'b1);
    run_cmd(1'b1, 5'd31, 5'd31, 16'h8000, 3'b000, 1'b0);
    for (int i = 0; i < 10; i++) begin
      logic wr;
      logic [4:0] a, r;
      logic [15:0] d;
      wr = 1'($urandom);
      a  = ($urandom % 2) ? PHY_ADDR : 5'($urandom);
      r  = 5'($urandom);
      d  = 16'($urandom);
      run_cmd(wr, a, r, d, 3'($urandom), 1'b0);
    end
    finish_run();
  end
endmodule